// File: doc/BRIEF.md
# Multi-Lane AES Inverse Round Unit

This block computes one round of AES decryption, in the equivalent-inverse-cipher arrangement, on up to four independent 128-bit lanes in parallel. Each lane takes its slice of a wide state vector and of a wide round-key vector. It undoes the row rotation, replaces each byte through the inverse substitution, unmixes each column, and then XORs in the lane's key. Because the key is added after the column unmixing, the caller must supply round keys that have already been passed through the inverse column mix. A control input selects the final-round variant, which skips the column unmixing.

A two-bit length select sets how many lanes are active. A mode bit chooses what happens to the result bits above the active width. In zeroing mode, every bit from the active width upward is cleared. In merge mode, only lane 0 is computed, and bits 128 and up are copied from a caller-supplied prior destination value. Operands enter through a valid/ready handshake, and the result leaves through another valid/ready handshake behind a single output register. The unit accepts a new operand while it holds a result only if that result is being taken in the same cycle. A result that is not taken stays on the output unchanged.

Top module: `aes_invround_mlane`

## Requirements
- R1: In a normal round (in_last=0), each lane's result is InvMixColumns(InvSubBytes(InvShiftRows(state))) XOR key. InvMixColumns multiplies each column by the circulant matrix {0E,0B,0D,09} over GF(2^8) modulo 0x11B. InvSubBytes is the standard AES inverse S-box (0x00 maps to 0x52, 0x63 maps to 0x00).
- R2: State byte k sits in bits [8k+7:8k]. Its row is k mod 4 and its column is k div 4. InvShiftRows rotates row r right by r columns, so output column c, row r takes input column (c-r) mod 4, row r.
- R3: With in_last=1, InvMixColumns is skipped and each lane's result is InvSubBytes(InvShiftRows(state)) XOR key.
- R4: Lane i uses bits [128i+127:128i] of in_state and in_key and writes the same bits of out_data. Lanes do not affect one another.
- R5: in_vlen sets the active lane count: 0 gives 1 lane, 1 gives 2 lanes, and 2 or 3 give 4 lanes.
- R6: With in_zero=1, every out_data bit at or above 128 × (active lanes) is 0.
- R7: With in_zero=0 (merge mode), only lane 0 is computed, whatever in_vlen is, and out_data[511:128] equals in_prior.
- R8: An operand is accepted on a rising edge where in_valid and in_ready are both 1. out_valid is 1 after that edge. in_ready equals !out_valid || out_ready.
- R9: While out_valid=1 and out_ready=0, out_data and out_valid stay unchanged.
- R10: While rst_n is low, out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Unit can take an operand |
| in_state | input | 512 | Four 128-bit state lanes |
| in_key | input | 512 | Four 128-bit round keys |
| in_prior | input | 384 | Prior destination bits 511:128 for merge mode |
| in_vlen | input | 2 | Active length select: 0 = 128, 1 = 256, 2 or 3 = 512 |
| in_zero | input | 1 | 1 = zero the bits above the active width, 0 = merge |
| in_last | input | 1 | 1 = final-round variant without InvMixColumns |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 512 | Registered round result |

## Verification
The bench builds the block with its default parameters: four lanes of 128 bits. This makes every length select reachable, including the reserved code 3, and lets both upper-bit policies act on a full 384-bit region above lane 0. Expected results come from a separate model in the bench. That model derives its inverse substitution table by inverting a forward S-box it builds itself, and it unmixes columns with doubling chains. Two fixed anchors need no model at all: a zero state normally yields 0x52 in every byte, and a state of all 0x63 in the final round yields the key unchanged. The handshake is exercised under held back-pressure, where a second operand is offered while the output is stalled.

// File: rtl/aes_invround_pkg.sv
package aes_invround_pkg;

  localparam int BYTE_W = 8;

  // GF(2^8) multiply, reduction polynomial 0x11B
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] x;
    acc = 8'h00;
    x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1B : 8'h00);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254 (0 maps to 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] p2, p3, p12, p15, p240, r;
    p2   = gf_mul(a, a);
    p3   = gf_mul(p2, a);
    p12  = gf_mul(p3, p3);
    p12  = gf_mul(p12, p12);
    p15  = gf_mul(p12, p3);
    p240 = gf_mul(p15, p15);
    p240 = gf_mul(p240, p240);
    p240 = gf_mul(p240, p240);
    p240 = gf_mul(p240, p240);
    r    = gf_mul(p240, p12);
    r    = gf_mul(r, p2);
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  // inverse of the S-box affine step
  function automatic logic [7:0] inv_affine(input logic [7:0] v);
    return rotl8(v, 1) ^ rotl8(v, 3) ^ rotl8(v, 6) ^ 8'h05;
  endfunction

endpackage

// File: rtl/aes_inv_sbox.sv
module aes_inv_sbox
  import aes_invround_pkg::*;
(
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout
);
  logic [BYTE_W-1:0] pre;

  always_comb begin
    pre  = inv_affine(din);
    dout = gf_inv(pre);
  end
endmodule

// File: rtl/aes_inv_mixcol.sv
module aes_inv_mixcol
  import aes_invround_pkg::*;
(
  input  logic [4*BYTE_W-1:0] col_in,
  output logic [4*BYTE_W-1:0] col_out
);
  logic [7:0] a0, a1, a2, a3;

  assign a0 = col_in[7:0];
  assign a1 = col_in[15:8];
  assign a2 = col_in[23:16];
  assign a3 = col_in[31:24];

  always_comb begin
    col_out[7:0]   = gf_mul(a0, 8'h0E) ^ gf_mul(a1, 8'h0B) ^ gf_mul(a2, 8'h0D) ^ gf_mul(a3, 8'h09);
    col_out[15:8]  = gf_mul(a0, 8'h09) ^ gf_mul(a1, 8'h0E) ^ gf_mul(a2, 8'h0B) ^ gf_mul(a3, 8'h0D);
    col_out[23:16] = gf_mul(a0, 8'h0D) ^ gf_mul(a1, 8'h09) ^ gf_mul(a2, 8'h0E) ^ gf_mul(a3, 8'h0B);
    col_out[31:24] = gf_mul(a0, 8'h0B) ^ gf_mul(a1, 8'h0D) ^ gf_mul(a2, 8'h09) ^ gf_mul(a3, 8'h0E);
  end
endmodule

// File: rtl/aes_inv_lane.sv
module aes_inv_lane
  import aes_invround_pkg::*;
#(
  parameter int LANE_W = 128
) (
  input  logic [LANE_W-1:0] state_in,
  input  logic [LANE_W-1:0] key_in,
  input  logic              last_rnd,
  output logic [LANE_W-1:0] lane_out
);
  localparam int NBYTES = LANE_W / BYTE_W;
  localparam int NCOLS  = NBYTES / 4;

  logic [LANE_W-1:0] shifted;
  logic [LANE_W-1:0] subbed;
  logic [LANE_W-1:0] unmixed;

  // R2: row r of output column c comes from input column (c-r) mod NCOLS
  for (genvar c = 0; c < NCOLS; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      localparam int SRC_COL = (c - r + NCOLS) % NCOLS;
      assign shifted[(4*c+r)*BYTE_W +: BYTE_W] = state_in[(4*SRC_COL+r)*BYTE_W +: BYTE_W];
    end
    aes_inv_mixcol u_mix (
      .col_in (subbed[c*4*BYTE_W +: 4*BYTE_W]),
      .col_out(unmixed[c*4*BYTE_W +: 4*BYTE_W])
    );
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_sub
    aes_inv_sbox u_sbox (
      .din (shifted[b*BYTE_W +: BYTE_W]),
      .dout(subbed[b*BYTE_W +: BYTE_W])
    );
  end

  // R1 / R3: key added after the optional column unmix
  assign lane_out = (last_rnd ? subbed : unmixed) ^ key_in;
endmodule

// File: rtl/aes_invround_mlane.sv
module aes_invround_mlane
  import aes_invround_pkg::*;
#(
  parameter int LANE_W    = 128,
  parameter int MAX_LANES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [LANE_W*MAX_LANES-1:0] in_state,
  input  logic [LANE_W*MAX_LANES-1:0] in_key,
  input  logic [LANE_W*MAX_LANES-1:LANE_W] in_prior,
  input  logic [1:0]                  in_vlen,
  input  logic                        in_zero,
  input  logic                        in_last,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [LANE_W*MAX_LANES-1:0] out_data
);
  localparam int TOT_W = LANE_W * MAX_LANES;

  logic [TOT_W-1:0] lane_res;
  logic [TOT_W-1:0] next_data;
  logic [2:0]       act_lanes;
  logic             accept;

  // R5: length select decode, clipped to the built lane count
  always_comb begin
    unique case (in_vlen)
      2'd0:    act_lanes = 3'd1;
      2'd1:    act_lanes = 3'd2;
      default: act_lanes = 3'd4;
    endcase
    if (int'(act_lanes) > MAX_LANES) act_lanes = 3'(MAX_LANES);
  end

  // R4: one independent datapath per lane
  for (genvar l = 0; l < MAX_LANES; l++) begin : g_lane
    aes_inv_lane #(.LANE_W(LANE_W)) u_lane (
      .state_in(in_state[l*LANE_W +: LANE_W]),
      .key_in  (in_key[l*LANE_W +: LANE_W]),
      .last_rnd(in_last),
      .lane_out(lane_res[l*LANE_W +: LANE_W])
    );
    if (l == 0) begin : g_base
      assign next_data[LANE_W-1:0] = lane_res[LANE_W-1:0];
    end else begin : g_upper
      // R6 / R7: upper-lane policy
      always_comb begin
        if (!in_zero)
          next_data[l*LANE_W +: LANE_W] = in_prior[l*LANE_W +: LANE_W];
        else if (l < int'(act_lanes))
          next_data[l*LANE_W +: LANE_W] = lane_res[l*LANE_W +: LANE_W];
        else
          next_data[l*LANE_W +: LANE_W] = '0;
      end
    end
  end

  // R8: single output stage
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) out_data <= next_data;
  end

  // R8
  r8_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R8
  r8_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R9
  r9_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R7
  r7_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_zero) |=> (out_data[TOT_W-1:LANE_W] == $past(in_prior)));

  // R6
  r6_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_zero && in_vlen == 2'd0) |=> (out_data[TOT_W-1:LANE_W] == '0));

  // R10
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r10_reset_chk: assert (!out_valid);
    end
  end
endmodule

// File: tb/aes_invround_mlane_tb.sv
module aes_invround_mlane_tb;
  localparam int LW = 128;
  localparam int NL = 4;
  localparam int TW = LW * NL;
  localparam time HALF = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [TW-1:0] in_state = '0;
  logic [TW-1:0] in_key = '0;
  logic [TW-1:LW] in_prior = '0;
  logic [1:0] in_vlen = 2'd0;
  logic in_zero = 1'b1;
  logic in_last = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [TW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] fwd [256];
  logic [7:0] inv [256];

  always #HALF clk = ~clk;

  aes_invround_mlane u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_state(in_state), .in_key(in_key), .in_prior(in_prior),
    .in_vlen(in_vlen), .in_zero(in_zero), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [7:0] xt(input logic [7:0] v);
    return {v[6:0], 1'b0} ^ (v[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [7:0] mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] s = 8'h00;
    logic [7:0] p = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) s ^= p;
      p = xt(p);
    end
    return s;
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  task automatic build_tables();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] iv = 8'h00;
      for (int y = 1; y < 256; y++)
        if (mul(8'(x), 8'(y)) == 8'h01) iv = 8'(y);
      fwd[x] = iv ^ rl(iv, 1) ^ rl(iv, 2) ^ rl(iv, 3) ^ rl(iv, 4) ^ 8'h63;
    end
    for (int x = 0; x < 256; x++) inv[fwd[x]] = 8'(x);
  endtask

  // model of one lane, built from doubling chains
  function automatic logic [LW-1:0] ref_lane(input logic [LW-1:0] s, input logic [LW-1:0] k,
                                             input logic lst);
    logic [7:0] m [16];
    logic [LW-1:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        m[4*c+r] = inv[s[(4*((c - r + 4) % 4) + r)*8 +: 8]];
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 4; r++) begin
        if (lst) begin
          o[(4*c+r)*8 +: 8] = m[4*c+r];
        end else begin
          logic [7:0] a  = m[4*c+r];
          logic [7:0] b  = m[4*c+(r+1)%4];
          logic [7:0] d  = m[4*c+(r+2)%4];
          logic [7:0] e  = m[4*c+(r+3)%4];
          logic [7:0] a2 = xt(a), a4 = xt(xt(a)), a8 = xt(xt(xt(a)));
          logic [7:0] b2 = xt(b), b8 = xt(xt(xt(b)));
          logic [7:0] d4 = xt(xt(d)), d8 = xt(xt(xt(d)));
          logic [7:0] e8 = xt(xt(xt(e)));
          o[(4*c+r)*8 +: 8] = (a8 ^ a4 ^ a2) ^ (b8 ^ b2 ^ b) ^ (d8 ^ d4 ^ d) ^ (e8 ^ e);
        end
      end
    end
    return o ^ k;
  endfunction

  function automatic logic [TW-1:0] ref_all(input logic [TW-1:0] s, input logic [TW-1:0] k,
      input logic [TW-1:LW] pr, input logic [1:0] vl, input logic z, input logic lst);
    logic [TW-1:0] o;
    int act = (vl == 2'd0) ? 1 : (vl == 2'd1) ? 2 : 4;
    o[LW-1:0] = ref_lane(s[LW-1:0], k[LW-1:0], lst);
    for (int l = 1; l < NL; l++) begin
      if (!z) o[l*LW +: LW] = pr[l*LW +: LW];
      else if (l < act) o[l*LW +: LW] = ref_lane(s[l*LW +: LW], k[l*LW +: LW], lst);
      else o[l*LW +: LW] = '0;
    end
    return o;
  endfunction

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic check_vec(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] pat(input int seed);
    logic [TW-1:0] v;
    for (int i = 0; i < TW / 32; i++) v[i*32 +: 32] = 32'(seed * 32'h9E3779B1 + i * 32'h7F4A7C15 + i * i);
    return v;
  endfunction

  // drive one operand, sample result at the following falling edge
  task automatic issue(input logic [TW-1:0] s, input logic [TW-1:0] k, input logic [TW-1:LW] pr,
                       input logic [1:0] vl, input logic z, input logic lst);
    @(negedge clk);
    in_state = s; in_key = k; in_prior = pr; in_vlen = vl; in_zero = z; in_last = lst;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    check_bit("R10 out_valid in reset", out_valid, 1'b0);
    check_bit("R8 ready when empty", in_ready, 1'b1);
  endtask

  task automatic t_anchor_zero();
    logic [TW-1:0] k = pat(3);
    logic [TW-1:0] exp = '0;
    exp[LW-1:0] = {16{8'h52}} ^ k[LW-1:0];
    issue('0, k, pat(4)[TW-1:LW], 2'd0, 1'b1, 1'b0);
    check_bit("R8 out_valid after accept", out_valid, 1'b1);
    check_vec("R1/R6 zero state anchor, 1 lane", out_data, exp);
  endtask

  task automatic t_anchor_last();
    logic [TW-1:0] k = pat(5);
    issue({64{8'h63}}, k, '0, 2'd2, 1'b1, 1'b1);
    check_vec("R3 last round 0x63 state gives key", out_data, k);
  endtask

  task automatic t_full(input int seed, input logic lst);
    logic [TW-1:0] s = pat(seed), k = pat(seed + 100);
    issue(s, k, pat(seed + 7)[TW-1:LW], 2'd2, 1'b1, lst);
    check_vec(lst ? "R3 four lanes last" : "R1/R2/R4 four lanes", out_data,
              ref_all(s, k, '0, 2'd2, 1'b1, lst));
  endtask

  task automatic t_two_lanes();
    logic [TW-1:0] s = pat(21), k = pat(22);
    issue(s, k, pat(23)[TW-1:LW], 2'd1, 1'b1, 1'b0);
    check_vec("R5/R6 two lanes zeroed above 256", out_data, ref_all(s, k, '0, 2'd1, 1'b1, 1'b0));
  endtask

  task automatic t_vlen3();
    logic [TW-1:0] s = pat(31), k = pat(32);
    issue(s, k, '0, 2'd3, 1'b1, 1'b0);
    check_vec("R5 code 3 gives four lanes", out_data, ref_all(s, k, '0, 2'd2, 1'b1, 1'b0));
  endtask

  task automatic t_merge(input logic [1:0] vl);
    logic [TW-1:0] s = pat(41 + vl), k = pat(51 + vl);
    logic [TW-1:LW] pr = pat(61 + vl)[TW-1:LW];
    issue(s, k, pr, vl, 1'b0, 1'b0);
    check_vec("R7 merge keeps prior upper bits", out_data, ref_all(s, k, pr, vl, 1'b0, 1'b0));
  endtask

  task automatic t_lane_indep();
    logic [TW-1:0] s = pat(71), k = pat(72), s2, exp;
    issue(s, k, '0, 2'd2, 1'b1, 1'b0);
    exp = out_data;
    s2 = s;
    s2[3*LW +: LW] = ~s2[3*LW +: LW];
    issue(s2, k, '0, 2'd2, 1'b1, 1'b0);
    check_vec("R4 lanes 0..2 unaffected by lane 3", {128'h0, out_data[3*LW-1:0]}, {128'h0, exp[3*LW-1:0]});
  endtask

  task automatic t_backpressure();
    logic [TW-1:0] sa = pat(81), ka = pat(82), sb = pat(83), kb = pat(84);
    logic [TW-1:0] ea = ref_all(sa, ka, '0, 2'd2, 1'b1, 1'b0);
    logic [TW-1:0] eb = ref_all(sb, kb, '0, 2'd2, 1'b1, 1'b1);
    @(negedge clk);
    out_ready = 1'b0;
    issue(sa, ka, '0, 2'd2, 1'b1, 1'b0);
    check_vec("R9 stalled result", out_data, ea);
    check_bit("R8 not ready while stalled", in_ready, 1'b0);
    in_state = sb; in_key = kb; in_last = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check_vec("R9 result held under back-pressure", out_data, ea);
    check_bit("R9 valid held", out_valid, 1'b1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_vec("R8 replacement accepted on drain", out_data, eb);
    @(negedge clk);
    check_bit("R8 valid drops after consume", out_valid, 1'b0);
  endtask

  logic done = 1'b0;

  initial begin
    #(HALF * 2 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    build_tables();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_anchor_zero();
    t_anchor_last();
    t_full(11, 1'b0);
    t_full(12, 1'b0);
    t_full(13, 1'b1);
    t_two_lanes();
    t_vlen3();
    t_merge(2'd0);
    t_merge(2'd2);
    t_lane_indep();
    t_backpressure();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule